// File: doc/BRIEF.md
# Legacy system I/O register block

This block is a byte-wide, port-mapped register file on a simple ISA-style I/O bus. It decodes single-byte reads and writes at a fixed set of twelve-bit port addresses. It holds three control registers: a soft-reset control port, a masked system-control register and an I/O-map-type register. It returns two board strap inputs (equipment and board identity) as read-only ports, returns zero from a keylock status port and accepts writes to four write-only ports with no side effect.

The soft-reset bit and the map-type bit each drive a registered output. Asking for the unsupported little-endian mode raises a one-cycle error pulse. A separate 32-bit parity-error status port accepts only 4-byte reads, always returns zero and flags any other access size. Register bits are numbered from the MSB: bit n has weight 8'h80 >> n, so bit 7 is 8'h01 and bit 0 is 8'h80.

Top module: `sysio_regblk`

## Requirements
- R1: A write to port 0x092 keeps only the value bit 8'h01 (bit 7). `soft_rst_o` shows the stored bit from the clock edge that takes the write. A read of 0x092 returns the stored value (8'h00 or 8'h01).
- R2: A write to port 0x092 with bit 8'h02 (bit 6, little-endian request) set drives `endian_err_o` high for exactly the one cycle after the accepting edge. Any other write leaves it low.
- R3: A write to port 0x081C stores `wdata & 8'hF0`, the four bits floppy-motor-inhibit 8'h10, bus-error-mask 8'h20, L2-update-inhibit 8'h40 and L2-miss-inhibit 8'h80. A read of 0x081C returns the stored value.
- R4: A write to port 0x0850 keeps only bit 8'h01 (non-contiguous map). `iomap_sparse_o` shows the stored bit from the accepting edge. A read of 0x0850 returns 8'h00 or 8'h01.
- R5: Synchronous reset (`rst` high at an edge) clears the soft-reset bit, the system-control register and both error flags, and sets the map-type bit, so `iomap_sparse_o` is 1 after reset.
- R6: Reads of port 0x080C return `equip_strap` and reads of port 0x0852 return `board_id_strap`. Writes to these ports change nothing.
- R7: A read of port 0x0818 returns 8'h00. Reads of the write-only ports 0x0808, 0x0810, 0x0812 and 0x0814, and of any undecoded address, return 8'hFF. Writes to the write-only ports change no register and no output.
- R8: `rdata` is valid in the same cycle as `rd_en` and is 8'h00 while `rd_en` is low.
- R9: `wide_rdata` always reads 0. A `wide_rd_en` with `wide_size` other than 4 drives `wide_size_err_o` high for the one cycle after that edge. A 4-byte read leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte port address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, same cycle as `rd_en` |
| equip_strap | input | 8 | Equipment strap value |
| board_id_strap | input | 8 | Board identity strap value |
| soft_rst_o | output | 1 | Soft-reset request from port 0x092 |
| iomap_sparse_o | output | 1 | Non-contiguous I/O map select |
| endian_err_o | output | 1 | Pulse: unsupported little-endian request |
| wide_rd_en | input | 1 | Parity status word read strobe |
| wide_size | input | 3 | Access size in bytes for the wide read |
| wide_rdata | output | 32 | Parity status word, always zero |
| wide_size_err_o | output | 1 | Pulse: wide access size other than 4 |

## Verification
The assertions assume that `wr_en` and `rd_en` are clean 0/1 strobes, that the strap inputs hold still while a read of their port is in flight, and that no access is issued in a cycle where `rst` is high. The bench drives strobes and addresses at the falling edge and keeps straps and reset constant around every access. It changes straps only between accesses. Random addresses come from the decoded port list mixed with arbitrary 12-bit values, so undecoded reads are covered as well as each register.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    localparam int ADDR_W     = 12;
    localparam int BYTE_W     = 8;
    localparam int WIDE_W     = 32;
    localparam int WIDE_BYTES = 4;
    localparam int SIZE_W     = 3;

    // MSB-first bit numbering: bit n carries weight 0x80 >> n
    function automatic logic [BYTE_W-1:0] msb_bit(input int unsigned n);
        return 8'h80 >> n;
    endfunction

    localparam logic [BYTE_W-1:0] SRST_MASK   = msb_bit(7);
    localparam logic [BYTE_W-1:0] ENDIAN_BIT  = msb_bit(6);
    localparam logic [BYTE_W-1:0] SYSCTL_MASK = msb_bit(0) | msb_bit(1) | msb_bit(2) | msb_bit(3);
    localparam logic [BYTE_W-1:0] IOMAP_MASK  = msb_bit(7);

    typedef enum int {
        P_RESET   = 0,
        P_LIGHT   = 1,
        P_EQUIP   = 2,
        P_PASS1   = 3,
        P_PASS2   = 4,
        P_L2INV   = 5,
        P_KEYLOCK = 6,
        P_SYSCTL  = 7,
        P_IOMAP   = 8,
        P_BOARDID = 9
    } port_idx_e;

    localparam int N_PORTS = 10;

    localparam logic [ADDR_W-1:0] PORT_ADDR [N_PORTS] = '{
        12'h092, 12'h808, 12'h80C, 12'h810, 12'h812,
        12'h814, 12'h818, 12'h81C, 12'h850, 12'h852
    };

    // access capability per port index
    localparam logic [N_PORTS-1:0] RD_CAP = 10'b11_1100_0101;
    localparam logic [N_PORTS-1:0] WR_CAP = 10'b01_1011_1011;

    typedef struct packed {
        logic              srst;
        logic [BYTE_W-1:0] sysctl;
        logic              iomap;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{srst: 1'b0, sysctl: '0, iomap: 1'b1};

endpackage

// File: rtl/sysio_addr_dec.sv
module sysio_addr_dec
    import sysio_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      addr,
    input  logic               rd_en,
    input  logic               wr_en,
    output logic [N_PORTS-1:0] rd_hit,
    output logic [N_PORTS-1:0] wr_hit
);

    logic [N_PORTS-1:0] match;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        assign match[i]  = (addr == AW'(PORT_ADDR[i]));
        assign rd_hit[i] = rd_en & match[i] & RD_CAP[i];
        assign wr_hit[i] = wr_en & match[i] & WR_CAP[i];
    end

    // R7
    wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit) && $onehot0(rd_hit));

endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
    import sysio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_srst,
    input  logic              wr_sysctl,
    input  logic              wr_iomap,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_state_t       state,
    output logic              endian_err
);

    ctrl_state_t nxt;

    always_comb begin
        nxt = state;
        if (wr_srst)   nxt.srst   = |(wdata & SRST_MASK);
        if (wr_sysctl) nxt.sysctl = wdata & SYSCTL_MASK;
        if (wr_iomap)  nxt.iomap  = |(wdata & IOMAP_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CTRL_RESET;
            endian_err <= 1'b0;
        end else begin
            state      <= nxt;
            endian_err <= wr_srst && ((wdata & ENDIAN_BIT) != '0);
        end
    end

    // R1
    srst_follow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_srst |=> state.srst == $past(wdata[0]));

    // R2
    endian_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_srst && wdata[1]) |=> endian_err);

    // R2
    endian_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_srst |=> !endian_err);

    // R3
    sysctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_sysctl |=> $stable(state.sysctl));

    // R4
    iomap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_iomap |=> $stable(state.iomap));

    // R5
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state.iomap && !state.srst && state.sysctl == '0 && !endian_err));

endmodule

// File: rtl/sysio_rd_mux.sv
module sysio_rd_mux
    import sysio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [N_PORTS-1:0] rd_hit,
    input  ctrl_state_t        state,
    input  logic [BYTE_W-1:0]  equip_strap,
    input  logic [BYTE_W-1:0]  board_id_strap,
    output logic [BYTE_W-1:0]  rdata
);

    logic [BYTE_W-1:0] port_val [N_PORTS];

    always_comb begin
        for (int i = 0; i < N_PORTS; i++) port_val[i] = 8'hFF;
        port_val[P_RESET]   = {{(BYTE_W-1){1'b0}}, state.srst};
        port_val[P_EQUIP]   = equip_strap;
        port_val[P_KEYLOCK] = '0;
        port_val[P_SYSCTL]  = state.sysctl;
        port_val[P_IOMAP]   = {{(BYTE_W-1){1'b0}}, state.iomap};
        port_val[P_BOARDID] = board_id_strap;
    end

    always_comb begin
        rdata = rd_en ? 8'hFF : 8'h00;
        for (int i = 0; i < N_PORTS; i++) begin
            if (rd_hit[i]) rdata = port_val[i];
        end
    end

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == 8'h00);

    // R3
    sysctl_mask_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit[P_SYSCTL] |-> (rdata & ~SYSCTL_MASK) == 8'h00);

    // R6
    strap_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit[P_EQUIP] |-> rdata == equip_strap);

endmodule

// File: rtl/sysio_wide_stat.sv
module sysio_wide_stat
    import sysio_pkg::*;
#(
    parameter int DW = WIDE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [SIZE_W-1:0] size,
    output logic [DW-1:0]     rdata,
    output logic              size_err
);

    assign rdata = '0;

    always_ff @(posedge clk) begin
        if (rst) size_err <= 1'b0;
        else     size_err <= rd_en && (size != SIZE_W'(WIDE_BYTES));
    end

    // R9
    size_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && size != 3'd4) |=> size_err);

    // R9
    size_ok_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && size != 3'd4) |=> !size_err);

endmodule

// File: rtl/sysio_regblk.sv
module sysio_regblk
    import sysio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic [7:0]        equip_strap,
    input  logic [7:0]        board_id_strap,
    output logic              soft_rst_o,
    output logic              iomap_sparse_o,
    output logic              endian_err_o,
    input  logic              wide_rd_en,
    input  logic [2:0]        wide_size,
    output logic [31:0]       wide_rdata,
    output logic              wide_size_err_o
);

    logic [N_PORTS-1:0] rd_hit;
    logic [N_PORTS-1:0] wr_hit;
    ctrl_state_t        state;

    sysio_addr_dec #(.AW(ADDR_W)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    sysio_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_srst    (wr_hit[P_RESET]),
        .wr_sysctl  (wr_hit[P_SYSCTL]),
        .wr_iomap   (wr_hit[P_IOMAP]),
        .wdata      (wdata),
        .state      (state),
        .endian_err (endian_err_o)
    );

    sysio_rd_mux u_mux (
        .clk            (clk),
        .rst            (rst),
        .rd_en          (rd_en),
        .rd_hit         (rd_hit),
        .state          (state),
        .equip_strap    (equip_strap),
        .board_id_strap (board_id_strap),
        .rdata          (rdata)
    );

    sysio_wide_stat #(.DW(WIDE_W)) u_wide (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (wide_rd_en),
        .size     (wide_size),
        .rdata    (wide_rdata),
        .size_err (wide_size_err_o)
    );

    assign soft_rst_o     = state.srst;
    assign iomap_sparse_o = state.iomap;

    // R7
    wo_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit[P_LIGHT] | wr_hit[P_PASS1] | wr_hit[P_PASS2] | wr_hit[P_L2INV])
        |=> $stable(state));

    // R4
    iomap_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 12'h850) |=> iomap_sparse_o == $past(wdata[0]));

endmodule

// File: tb/sysio_regblk_tb_top.sv
module sysio_regblk_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [7:0]  equip_strap = 8'h3C;
    logic [7:0]  board_id_strap = 8'hA5;
    logic        soft_rst_o, iomap_sparse_o, endian_err_o;
    logic        wide_rd_en = 1'b0;
    logic [2:0]  wide_size = 3'd4;
    logic [31:0] wide_rdata;
    logic        wide_size_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic       m_srst, m_iomap;
    logic [7:0] m_sysctl;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysio_regblk dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .equip_strap(equip_strap),
        .board_id_strap(board_id_strap), .soft_rst_o(soft_rst_o),
        .iomap_sparse_o(iomap_sparse_o), .endian_err_o(endian_err_o),
        .wide_rd_en(wide_rd_en), .wide_size(wide_size),
        .wide_rdata(wide_rdata), .wide_size_err_o(wide_size_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h092: return {7'b0, m_srst};
            12'h80C: return equip_strap;
            12'h852: return board_id_strap;
            12'h818: return 8'h00;
            12'h81C: return m_sysctl;
            12'h850: return {7'b0, m_iomap};
            default: return 8'hFF;
        endcase
    endfunction

    function automatic string req_of(input logic [11:0] a);
        case (a)
            12'h092: return "R1";
            12'h81C: return "R3";
            12'h850: return "R4";
            12'h80C, 12'h852: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic model_reset();
        m_srst = 1'b0; m_sysctl = 8'h00; m_iomap = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        model_reset();
        #1;
        chk("R5 soft_rst", soft_rst_o, 0);
        chk("R5 iomap", iomap_sparse_o, 1);
        chk("R5 endian", endian_err_o, 0);
        chk("R5 wide_err", wide_size_err_o, 0);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        logic e;
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        e = (a == 12'h092) && d[1];
        case (a)
            12'h092: m_srst = d[0];
            12'h81C: m_sysctl = d & 8'hF0;
            12'h850: m_iomap = d[0];
            default: ;
        endcase
        @(posedge clk); #1;
        chk("R2 endian pulse", endian_err_o, e);
        chk("R1 soft_rst_o", soft_rst_o, m_srst);
        chk("R4 iomap_sparse_o", iomap_sparse_o, m_iomap);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #1;
        chk("R2 endian clears", endian_err_o, 0);
    endtask

    task automatic do_read(input logic [11:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(req_of(a), rdata, exp_rd(a));
        @(negedge clk); rd_en = 1'b0;
        #1;
        chk("R8 idle rdata", rdata, 0);
    endtask

    task automatic do_wide(input logic [2:0] sz);
        @(negedge clk);
        wide_rd_en = 1'b1; wide_size = sz;
        #1;
        chk("R9 wide_rdata", wide_rdata, 0);
        @(posedge clk); #1;
        chk("R9 size_err", wide_size_err_o, (sz != 3'd4));
        @(negedge clk); wide_rd_en = 1'b0;
        @(posedge clk); #1;
        chk("R9 size_err clears", wide_size_err_o, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [11:0] ADDRS [10] = '{
        12'h092, 12'h808, 12'h80C, 12'h810, 12'h812,
        12'h814, 12'h818, 12'h81C, 12'h850, 12'h852
    };

    initial begin
        int unsigned seed;
        seed = 32'd7;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        do_reset();
        do_read(12'h850);
        do_read(12'h81C);
        do_read(12'h092);

        // R1 / R2 directed
        do_write(12'h092, 8'hFF);
        do_read(12'h092);
        do_write(12'h092, 8'h02);
        do_write(12'h092, 8'h01);
        do_write(12'h092, 8'hFC);
        do_read(12'h092);
        // R3 masking
        do_write(12'h81C, 8'hFF);
        do_read(12'h81C);
        do_write(12'h81C, 8'h0F);
        do_read(12'h81C);
        do_write(12'h81C, 8'hA3);
        do_read(12'h81C);
        // R4
        do_write(12'h850, 8'hFE);
        do_read(12'h850);
        do_write(12'h850, 8'h01);
        // R6 writes to straps ignored
        do_write(12'h80C, 8'h00);
        do_write(12'h852, 8'h00);
        do_read(12'h80C);
        do_read(12'h852);
        // R7 write-only, keylock, undecoded
        do_write(12'h808, 8'hFF);
        do_write(12'h810, 8'hFF);
        do_write(12'h812, 8'hFF);
        do_write(12'h814, 8'hFF);
        do_write(12'h818, 8'hFF);
        do_read(12'h81C);
        do_read(12'h850);
        do_read(12'h092);
        for (int i = 0; i < 10; i++) do_read(ADDRS[i]);
        do_read(12'h000);
        do_read(12'hFFF);
        do_read(12'h093);
        // R9 sizes
        for (int s = 0; s < 8; s++) do_wide(3'(s));

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            int unsigned k;
            k = $urandom % 16;
            a = (k < 10) ? ADDRS[k] : 12'($urandom);
            case ($urandom % 7)
                0, 1, 2: do_write(a, 8'($urandom));
                3, 4, 5: do_read(a);
                default: begin
                    if (($urandom % 2) == 0) begin
                        @(negedge clk);
                        equip_strap = 8'($urandom);
                        board_id_strap = 8'($urandom);
                    end
                    do_wide(3'($urandom));
                end
            endcase
        end

        // R5 mid-run reset
        do_write(12'h81C, 8'hF0);
        do_write(12'h092, 8'h01);
        do_write(12'h850, 8'h00);
        do_reset();
        do_read(12'h81C);
        do_read(12'h850);
        do_read(12'h092);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule